// File: doc/BRIEF.md
# PAL Raster Timing Generator

This block turns a 16 MHz pixel clock into the complete set of timing strobes for a 312-line, 50 Hz PAL raster. Two counters, one for the clock position within a scanline and one for the scanline within a frame, drive a decode stage. That stage produces an active-low line sync, an active-low composite sync, a flag that marks the pixel window, the pixel column and display row inside that window, and a one-clock event at the bottom of the picture. A video fetch engine uses this event as its frame interrupt.

A line is 1024 clocks, which is 64 µs. Line sync covers the first 75 clocks of each line. The pixel window opens at clock 264, a multiple of 8 so that it lines up with the memory slot pattern, and it stays open for 640 clocks. Vertical sync fills lines 0 to 2 of the frame. The picture starts on line 38 and is at most 256 lines tall. A height input can shorten the picture. Lines below the shortened picture stay blank but are still counted, so the frame period does not change.

All positions and lengths are parameters. The defaults give the PAL raster described above.

Top module: `pal_raster_gen`

## Requirements
- R1: The column counter steps once per clock and returns to 0 after LINE_CLKS clocks (default 1024), so line syncs begin exactly LINE_CLKS clocks apart.
- R2: The line counter steps at the end of each line and returns to 0 after FRAME_LINES lines (default 312), so a frame lasts FRAME_LINES × LINE_CLKS clocks.
- R3: `hsync_n` is 0 for columns 0 to HS_CLKS-1 (default 0 to 74) and 1 for every other column.
- R4: `csync_n` is 0 when `hsync_n` is 0 or when the line is one of lines 0 to VS_LINES-1 (default 0 to 2). Otherwise it is 1.
- R5: `disp_en` is 1 exactly when the column lies in [PIX_START, PIX_START+PIX_LEN) (default [264, 904)) and the line lies in [DISP_START, DISP_START+H) (default start 38). H is the picture height in effect for the frame.
- R6: `pix_col` equals column − PIX_START while `disp_en` is 1, and 0 otherwise. `disp_row` equals line − DISP_START on a displayed line, and 0 otherwise.
- R7: `vs_evt` is 1 for one clock only, at column 0 of line DISP_START+H, the line after the last displayed line. It is never 1 together with `disp_en`.
- R8: The height in effect is H = min(`height`, DISP_LINES). A height of 0 shows no lines, and then `vs_evt` falls at column 0 of line DISP_START.
- R9: `height` is sampled only on the last clock of a frame. A change to `height` during a frame has no effect on that frame. After reset, H is DISP_LINES until the first frame boundary.
- R10: While reset is held, and on the first clock after it, the block sits at line 0, column 0: `hsync_n`=0, `csync_n`=0, `disp_en`=0, `pix_col`=0, `disp_row`=0 and `vs_evt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| height | input | HTW (default 9) | Requested picture height in lines, sampled at the frame boundary |
| hsync_n | output | 1 | Line sync, active low |
| csync_n | output | 1 | Composite sync (line or vertical sync), active low |
| disp_en | output | 1 | Pixel window active |
| pix_col | output | CW (default 10) | Pixel column inside the window |
| disp_row | output | RW (default 8) | Display row inside the picture |
| vs_evt | output | 1 | One-clock bottom-of-picture event |

## Verification
The embedded assertions check the following on every clock:
- counter stepping and wrap;
- the line sync length;
- that composite sync follows line sync;
- that the pixel window never overlaps any sync;
- that the column advances by one inside the window and the row holds steady across a line;
- that the height latch changes only at a frame boundary and never exceeds its limit;
- that the event is a single clock outside the window.

Where the picture ends for a given height, when a height change takes effect, and whether the sync and frame periods add up across whole frames, can only be shown by the bench. It runs frames with full, shortened, zero and over-range heights and changes the height in the middle of a frame.

// File: rtl/pal_raster_pkg.sv
package pal_raster_pkg;

  // True when v lies in the half-open span [lo, lo+len).
  function automatic logic in_span(int v, int lo, int len);
    return (v >= lo) && (v < lo + len);
  endfunction

  // Limit a requested line count to the largest supported picture.
  function automatic int clamp_lines(int req, int lim);
    return (req > lim) ? lim : req;
  endfunction

  // Position of v relative to the start of a span.
  function automatic int offset_in(int v, int lo);
    return v - lo;
  endfunction

endpackage

// File: rtl/pal_raster_hcount.sv
module pal_raster_hcount
  import pal_raster_pkg::*;
#(
  parameter int LINE_CLKS = 1024,
  parameter int HS_CLKS   = 75,
  parameter int PIX_START = 264,
  parameter int PIX_LEN   = 640,
  parameter int HW        = $clog2(LINE_CLKS),
  parameter int CW        = $clog2(PIX_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          line_start,
  output logic          line_end,
  output logic          hs_active,
  output logic          pix_win,
  output logic [CW-1:0] col_raw
);

  logic [HW-1:0] h_cnt;

  always_ff @(posedge clk) begin
    if (rst)           h_cnt <= '0;
    else if (line_end) h_cnt <= '0;
    else               h_cnt <= h_cnt + HW'(1);
  end

  always_comb begin
    line_start = (h_cnt == '0);
    line_end   = (int'(h_cnt) == LINE_CLKS - 1);
    hs_active  = (int'(h_cnt) < HS_CLKS);
    pix_win    = in_span(int'(h_cnt), PIX_START, PIX_LEN);
    col_raw    = pix_win ? CW'(offset_in(int'(h_cnt), PIX_START)) : '0;
  end

  // R1: the column returns to 0 after the last clock of a line
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    line_end |=> line_start);

  // R1: outside the wrap the column advances by exactly one
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> int'(h_cnt) == int'($past(h_cnt)) + 1);

  // R3: line sync ends at column HS_CLKS
  a_r3_hs_end: assert property (@(posedge clk) disable iff (rst)
    $fell(hs_active) |-> int'(h_cnt) == HS_CLKS);

  // R3: every line begins inside line sync
  a_r3_hs_begin: assert property (@(posedge clk) disable iff (rst)
    line_start |-> hs_active);

endmodule

// File: rtl/pal_raster_vcount.sv
module pal_raster_vcount
  import pal_raster_pkg::*;
#(
  parameter int FRAME_LINES = 312,
  parameter int VS_LINES    = 3,
  parameter int DISP_START  = 38,
  parameter int DISP_LINES  = 256,
  parameter int VW          = $clog2(FRAME_LINES),
  parameter int HTW         = $clog2(DISP_LINES + 1),
  parameter int RW          = $clog2(DISP_LINES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           line_end,
  input  logic [HTW-1:0] height,
  output logic           frame_end,
  output logic           vs_active,
  output logic           disp_line,
  output logic [RW-1:0]  row_raw,
  output logic           evt_line
);

  logic [VW-1:0]  v_cnt;
  logic [HTW-1:0] eff_q;

  always_comb frame_end = line_end && (int'(v_cnt) == FRAME_LINES - 1);

  always_ff @(posedge clk) begin
    if (rst)            v_cnt <= '0;
    else if (frame_end) v_cnt <= '0;
    else if (line_end)  v_cnt <= v_cnt + VW'(1);
  end

  // The picture height is taken only on the last clock of a frame.
  always_ff @(posedge clk) begin
    if (rst)            eff_q <= HTW'(DISP_LINES);
    else if (frame_end) eff_q <= HTW'(clamp_lines(int'(height), DISP_LINES));
  end

  always_comb begin
    vs_active = (int'(v_cnt) < VS_LINES);
    disp_line = in_span(int'(v_cnt), DISP_START, int'(eff_q));
    row_raw   = disp_line ? RW'(offset_in(int'(v_cnt), DISP_START)) : '0;
    evt_line  = (int'(v_cnt) == DISP_START + int'(eff_q));
  end

  // R2: the line counter returns to 0 after the last line of a frame
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> v_cnt == '0);

  // R2: the line counter moves only at a line end
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> $stable(v_cnt));

  // R9: the height in effect changes only at a frame boundary
  a_r9_height_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(eff_q));

  // R8: the height in effect never exceeds the picture limit
  a_r8_clamp: assert property (@(posedge clk) disable iff (rst)
    int'(eff_q) <= DISP_LINES);

  // R6: the display row stays the same across a whole line
  a_r6_row_stable: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> $stable(row_raw));

endmodule

// File: rtl/pal_raster_out.sv
module pal_raster_out #(
  parameter int CW = 10,
  parameter int RW = 8
) (
  input  logic          hs_active,
  input  logic          vs_active,
  input  logic          pix_win,
  input  logic          disp_line,
  input  logic          line_start,
  input  logic          evt_line,
  input  logic [CW-1:0] col_raw,
  input  logic [RW-1:0] row_raw,
  output logic          hsync_n,
  output logic          csync_n,
  output logic          disp_en,
  output logic [CW-1:0] pix_col,
  output logic [RW-1:0] disp_row,
  output logic          vs_evt
);

  always_comb begin
    hsync_n  = !hs_active;
    csync_n  = !(hs_active || vs_active);
    disp_en  = pix_win && disp_line;
    pix_col  = disp_en ? col_raw : '0;
    disp_row = row_raw;
    vs_evt   = evt_line && line_start;
  end

endmodule

// File: rtl/pal_raster_gen.sv
module pal_raster_gen #(
  parameter int LINE_CLKS   = 1024,
  parameter int HS_CLKS     = 75,
  parameter int PIX_START   = 264,
  parameter int PIX_LEN     = 640,
  parameter int FRAME_LINES = 312,
  parameter int VS_LINES    = 3,
  parameter int DISP_START  = 38,
  parameter int DISP_LINES  = 256,
  parameter int HTW         = $clog2(DISP_LINES + 1),
  parameter int CW          = $clog2(PIX_LEN),
  parameter int RW          = $clog2(DISP_LINES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HTW-1:0] height,
  output logic           hsync_n,
  output logic           csync_n,
  output logic           disp_en,
  output logic [CW-1:0]  pix_col,
  output logic [RW-1:0]  disp_row,
  output logic           vs_evt
);

  localparam int HW = $clog2(LINE_CLKS);
  localparam int VW = $clog2(FRAME_LINES);

  logic          line_start, line_end, hs_active, pix_win;
  logic          frame_end, vs_active, disp_line, evt_line;
  logic [CW-1:0] col_raw;
  logic [RW-1:0] row_raw;

  pal_raster_hcount #(
    .LINE_CLKS(LINE_CLKS), .HS_CLKS(HS_CLKS), .PIX_START(PIX_START),
    .PIX_LEN(PIX_LEN), .HW(HW), .CW(CW)
  ) u_h (
    .clk(clk), .rst(rst), .line_start(line_start), .line_end(line_end),
    .hs_active(hs_active), .pix_win(pix_win), .col_raw(col_raw)
  );

  pal_raster_vcount #(
    .FRAME_LINES(FRAME_LINES), .VS_LINES(VS_LINES), .DISP_START(DISP_START),
    .DISP_LINES(DISP_LINES), .VW(VW), .HTW(HTW), .RW(RW)
  ) u_v (
    .clk(clk), .rst(rst), .line_end(line_end), .height(height),
    .frame_end(frame_end), .vs_active(vs_active), .disp_line(disp_line),
    .row_raw(row_raw), .evt_line(evt_line)
  );

  pal_raster_out #(.CW(CW), .RW(RW)) u_o (
    .hs_active(hs_active), .vs_active(vs_active), .pix_win(pix_win),
    .disp_line(disp_line), .line_start(line_start), .evt_line(evt_line),
    .col_raw(col_raw), .row_raw(row_raw),
    .hsync_n(hsync_n), .csync_n(csync_n), .disp_en(disp_en),
    .pix_col(pix_col), .disp_row(disp_row), .vs_evt(vs_evt)
  );

  // R4: line sync always appears on composite sync
  a_r4_csync_hs: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> !csync_n);

  // R5: the pixel window never overlaps any sync
  a_r5_no_sync_window: assert property (@(posedge clk) disable iff (rst)
    disp_en |-> hsync_n && csync_n);

  // R6: inside the window the column advances by one per clock
  a_r6_col_step: assert property (@(posedge clk) disable iff (rst)
    (disp_en && int'(pix_col) != PIX_LEN - 1) |=>
      disp_en && int'(pix_col) == int'($past(pix_col)) + 1);

  // R7: the bottom event lasts a single clock
  a_r7_single: assert property (@(posedge clk) disable iff (rst)
    vs_evt |=> !vs_evt);

  // R7: the bottom event falls outside the pixel window
  a_r7_blank: assert property (@(posedge clk) disable iff (rst)
    vs_evt |-> !disp_en);

  // R10: the first clock after reset is at column 0, line 0
  a_r10_start: assert property (@(posedge clk)
    rst |=> !hsync_n && !csync_n && !disp_en && !vs_evt);

endmodule

// File: tb/tb_pal_raster_gen.sv
`timescale 1ns/1ps
module tb_pal_raster_gen;

  localparam int L   = 64;
  localparam int HS  = 5;
  localparam int PS  = 16;
  localparam int PL  = 40;
  localparam int F   = 20;
  localparam int VS  = 3;
  localparam int DS  = 6;
  localparam int DL  = 12;
  localparam int HTW = $clog2(DL + 1);
  localparam int CW  = $clog2(PL);
  localparam int RW  = $clog2(DL);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [HTW-1:0] height = HTW'(DL);
  logic           hsync_n, csync_n, disp_en, vs_evt;
  logic [CW-1:0]  pix_col;
  logic [RW-1:0]  disp_row;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pal_raster_gen #(
    .LINE_CLKS(L), .HS_CLKS(HS), .PIX_START(PS), .PIX_LEN(PL),
    .FRAME_LINES(F), .VS_LINES(VS), .DISP_START(DS), .DISP_LINES(DL)
  ) dut (
    .clk(clk), .rst(rst), .height(height), .hsync_n(hsync_n),
    .csync_n(csync_n), .disp_en(disp_en), .pix_col(pix_col),
    .disp_row(disp_row), .vs_evt(vs_evt)
  );

  typedef struct {
    bit in_rst;
    bit hs_n, cs_n, de, evt;
    int col, row;
  } exp_t;

  exp_t exp_q[$];
  int   exp_h[$];

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  // Reference raster, stepped independently on each edge.
  int mh = 0, mv = 0, meff = DL;
  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      mh = 0; mv = 0; meff = DL;
    end else if (mh == L - 1) begin
      mh = 0;
      if (mv == F - 1) begin
        mv = 0;
        meff = (int'(height) > DL) ? DL : int'(height);
      end else mv++;
    end else mh++;
    e.in_rst = rst;
    e.hs_n = !(mh < HS);
    e.cs_n = !(mh < HS || mv < VS);
    e.de   = (mv >= DS && mv < DS + meff) && (mh >= PS && mh < PS + PL);
    e.col  = e.de ? mh - PS : 0;
    e.row  = (mv >= DS && mv < DS + meff) ? mv - DS : 0;
    e.evt  = (mh == 0) && (mv == DS + meff);
    exp_q.push_back(e);
  end

  // Monitor: compare each clock's outputs, and measure periods and heights.
  int  cyc = 0;
  int  last_hs_fall = -1;
  int  last_vs_rise = -1, last_frame_rise = -1;
  bit  p_hs = 1'b1, p_vsonly = 1'b0, p_de = 1'b0;
  int  lines_seen = 0;
  int  frame_idx = 0;
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      string rq;
      e = exp_q.pop_front();
      cyc++;
      rq = e.in_rst ? "R10" : "";
      check(hsync_n == e.hs_n, e.in_rst ? rq : "R3", "hsync_n", hsync_n, e.hs_n);
      check(csync_n == e.cs_n, e.in_rst ? rq : "R4", "csync_n", csync_n, e.cs_n);
      check(disp_en == e.de,   e.in_rst ? rq : "R5", "disp_en", disp_en, e.de);
      check(int'(pix_col) == e.col,  e.in_rst ? rq : "R6", "pix_col", int'(pix_col), e.col);
      check(int'(disp_row) == e.row, e.in_rst ? rq : "R6", "disp_row", int'(disp_row), e.row);
      check(vs_evt == e.evt,   e.in_rst ? rq : "R7", "vs_evt", vs_evt, e.evt);
      if (!e.in_rst) begin
        // R1: line sync periods
        if (p_hs && !hsync_n) begin
          if (last_hs_fall >= 0)
            check(cyc - last_hs_fall == L, "R1", "line period", cyc - last_hs_fall, L);
          last_hs_fall = cyc;
        end
        // R2: vertical-only sync begins once per frame
        if (!p_vsonly && (!csync_n && hsync_n)) begin
          if (last_vs_rise < 0 || cyc - last_vs_rise > L) begin
            if (last_frame_rise >= 0)
              check(cyc - last_frame_rise == F * L, "R2", "frame period",
                    cyc - last_frame_rise, F * L);
            last_frame_rise = cyc;
          end
          last_vs_rise = cyc;
        end
        if (!p_de && disp_en) lines_seen++;
        // R8 / R9: displayed lines per frame
        if (vs_evt) begin
          if (exp_h.size() > 0) begin
            int eh;
            eh = exp_h.pop_front();
            check(lines_seen == eh, frame_idx == 0 ? "R9" : "R8", "lines shown",
                  lines_seen, eh);
          end
          frame_idx++;
          lines_seen = 0;
        end
      end
      p_hs = hsync_n;
      p_vsonly = !csync_n && hsync_n;
      p_de = disp_en;
    end
  end

  task automatic wait_evt();
    @(posedge vs_evt);
    @(negedge clk);
  endtask

  task automatic wait_de_rises(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge disp_en);
    end
    @(negedge clk);
  endtask

  // Driver: sets heights and pushes the line count expected per frame.
  initial begin
    exp_h.push_back(DL);             // frame 0: reset height, R9
    repeat (4) @(negedge clk);
    rst = 1'b0;
    wait_de_rises(3);
    height = HTW'(5);                // mid-frame change, applies next frame
    exp_h.push_back(5);              // frame 1
    wait_evt();                      // end of frame 0 picture
    wait_evt();                      // end of frame 1 picture
    height = HTW'(0);
    exp_h.push_back(0);              // frame 2: empty picture, R8
    wait_evt();
    height = HTW'(15);
    exp_h.push_back(DL);             // frame 3: clamped, R8
    wait_evt();
    height = HTW'(1);
    exp_h.push_back(1);              // frame 4
    wait_evt();
    wait_evt();
    repeat (L * 3) @(negedge clk);
    check(exp_h.size() == 0, "R8", "frames left unchecked", exp_h.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule